// File: doc/BRIEF.md
# Precision Timer with Fixed-Interval Pulses

This block keeps a 64-bit nanosecond time of day for a precision time protocol engine and derives periodic timing outputs from it. It is clocked by a free-running timer oscillator. A 32-bit fractional accumulator adds a programmed addend on every oscillator cycle. Each carry out of the accumulator is one nominal tick. The frequency of the tick is trimmed by changing the addend. The nominal addend is ceil(2^32 / ratio), where ratio is the oscillator frequency divided by the nominal tick frequency. The ratio has to be above 1.0, so an addend below 2^32 gives at most one tick per oscillator cycle.

On each tick the time counter adds the programmed tick period in whole nanoseconds. A prescaler divides the tick stream into an output clock, which is presented as a one-cycle strobe per output period. Two independent interval generators each count a programmed interval down by the tick period. When the count runs out, the generator emits a pulse that lasts one output-clock period. The interval is programmed as the desired pulse period minus one tick period. For example, 999,999,990 gives one pulse per second at a 10 ns tick.

Software programs the block through plain write-enable/data ports for the addend, tick period, prescale and intervals, and can load the time counter directly.

Top module: `ptp_fiper_timer`

## Requirements
- R1: After reset the time is 0, and `tick`, `oclk_stb` and both `pulse` bits are 0. The addend, tick period, prescale and intervals are all 0.
- R2: A written addend takes effect on the following cycle. Starting from accumulator phase zero, the number of `tick` cycles in the N cycles after that is floor(N × addend / 2^32). An addend of 0 gives no ticks.
- R3: Every cycle with `tick` high advances `time_ns` by the tick period on the next clock edge.
- R4: A time load makes `time_ns` equal to the loaded value after the write edge. The load overrides a tick that would have been applied at the same edge.
- R5: Changing the addend while running causes no time step. The time always equals the last loaded value plus the tick period times the number of ticks since then.
- R6: Writing the prescale P restarts the division. After that, `oclk_stb` pulses once for every P ticks, giving floor(ticks / P) strobes. P = 0 gives no strobes.
- R7: After interval V is written to generator g with tick period T (T > 0), `pulse[g]` rises once every floor(V / T) + 1 ticks. The first rise comes after that many ticks.
- R8: Each pulse stays high for exactly P ticks, where P is the prescale. That is one output-clock period.
- R9: An interval of 0, or a prescale of 0, produces no pulses on that generator.
- R10: The two generators are independent. Writing to one (`ivl_we` bit g selects generator g) does not change the other's pulse train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addend_we | input | 1 | Write strobe for the frequency addend |
| addend_wdata | input | 32 | New addend value |
| period_we | input | 1 | Write strobe for the tick period |
| period_wdata | input | PER_W | Tick period in ns |
| prsc_we | input | 1 | Write strobe for the prescale |
| prsc_wdata | input | PRSC_W | Prescale divider (0 disables) |
| ivl_we | input | N_IVL | Per-generator interval write strobes |
| ivl_wdata | input | IVL_W | Interval value in ns (0 disables) |
| time_we | input | 1 | Load strobe for the time counter |
| time_wdata | input | 64 | Time value to load |
| tick | output | 1 | One-cycle nominal tick |
| time_ns | output | 64 | Current time in ns |
| oclk_stb | output | 1 | One-cycle strobe per output-clock period |
| pulse | output | N_IVL | Interval pulse outputs |

## Verification
A wrong accumulator state shows up as a tick count that differs from floor(N × addend / 2^32) within a few thousand cycles, and as a time that drifts from the tick period times the observed ticks. A wrong prescaler or countdown value changes the number of ticks between pulse rises, or the number of ticks a pulse stays high. This is visible at the first or second pulse after the interval is written. A time load that loses to a concurrent tick, or a step on addend change, breaks the time equation on the very next read.

// File: rtl/ptp_tmr_pkg.sv
package ptp_tmr_pkg;
  localparam int ACC_W  = 32;
  localparam int TIME_W = 64;
endpackage

// File: rtl/ptp_tick_gen.sv
module ptp_tick_gen
  import ptp_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addend_we,
  input  logic [ACC_W-1:0] addend_wdata,
  output logic             tick
);
  logic [ACC_W-1:0] addend_q, addend_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             tick_q, tick_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, addend_q};
    acc_d    = sum[ACC_W-1:0];
    tick_d   = sum[ACC_W];
    addend_d = addend_we ? addend_wdata : addend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addend_q <= '0;
      acc_q    <= '0;
      tick_q   <= 1'b0;
    end else begin
      addend_q <= addend_d;
      acc_q    <= acc_d;
      tick_q   <= tick_d;
    end
  end

  assign tick = tick_q;

  // R2
  tick_needs_addend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> ($past(addend_q) != '0));
endmodule

// File: rtl/ptp_ns_counter.sv
module ptp_ns_counter
  import ptp_tmr_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              period_we,
  input  logic [PER_W-1:0]  period_wdata,
  input  logic              time_we,
  input  logic [TIME_W-1:0] time_wdata,
  output logic [TIME_W-1:0] time_ns,
  output logic [PER_W-1:0]  period
);
  logic [TIME_W-1:0] time_q, time_d;
  logic [PER_W-1:0]  period_q, period_d;

  always_comb begin
    period_d = period_we ? period_wdata : period_q;
    time_d   = time_q;
    if (time_we)   time_d = time_wdata;
    else if (tick) time_d = time_q + TIME_W'(period_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q   <= '0;
      period_q <= '0;
    end else begin
      time_q   <= time_d;
      period_q <= period_d;
    end
  end

  assign time_ns = time_q;
  assign period  = period_q;

  // R3
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !time_we) |=> (time_q == $past(time_q) + TIME_W'($past(period_q))));
  // R4
  time_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_we |=> (time_q == $past(time_wdata)));
  // R5
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !time_we) |=> $stable(time_q));
endmodule

// File: rtl/ptp_prescaler.sv
module ptp_prescaler #(
  parameter int PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              prsc_we,
  input  logic [PRSC_W-1:0] prsc_wdata,
  output logic              oclk_stb,
  output logic [PRSC_W-1:0] prsc
);
  logic [PRSC_W-1:0] prsc_q, prsc_d;
  logic [PRSC_W-1:0] cnt_q, cnt_d;
  logic              stb_q, stb_d;
  logic              active;

  always_comb begin
    active = tick && (prsc_q != '0);
    prsc_d = prsc_q;
    cnt_d  = cnt_q;
    stb_d  = 1'b0;
    if (prsc_we) begin
      prsc_d = prsc_wdata;
      cnt_d  = '0;
    end else if (active) begin
      if (cnt_q == prsc_q - 1'b1) begin
        cnt_d = '0;
        stb_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prsc_q <= '0;
      cnt_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      prsc_q <= prsc_d;
      cnt_q  <= cnt_d;
      stb_q  <= stb_d;
    end
  end

  assign oclk_stb = stb_q;
  assign prsc     = prsc_q;

  // R6
  stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> ($past(tick) && ($past(prsc_q) != '0)));
  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prsc_q != '0) |-> (cnt_q < prsc_q));
endmodule

// File: rtl/ptp_ivl_gen.sv
module ptp_ivl_gen #(
  parameter int PER_W  = 8,
  parameter int PRSC_W = 16,
  parameter int IVL_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [PER_W-1:0]  period,
  input  logic [PRSC_W-1:0] prsc,
  input  logic              ivl_we,
  input  logic [IVL_W-1:0]  ivl_wdata,
  output logic              pulse
);
  logic [IVL_W-1:0]  ivl_q, ivl_d;
  logic [IVL_W-1:0]  rem_q, rem_d;
  logic              pulse_q, pulse_d;
  logic [PRSC_W-1:0] wcnt_q, wcnt_d;
  logic              expire, fire;

  always_comb begin
    expire  = tick && (ivl_q != '0) && (rem_q < IVL_W'(period));
    fire    = expire && (prsc != '0);
    ivl_d   = ivl_q;
    rem_d   = rem_q;
    pulse_d = pulse_q;
    wcnt_d  = wcnt_q;
    if (ivl_we) begin
      ivl_d = ivl_wdata;
      rem_d = ivl_wdata;
    end else if (expire) begin
      rem_d = ivl_q;
    end else if (tick && ivl_q != '0) begin
      rem_d = rem_q - IVL_W'(period);
    end
    if (fire && !ivl_we) begin
      pulse_d = 1'b1;
      wcnt_d  = prsc - 1'b1;
    end else if (tick && pulse_q) begin
      if (wcnt_q == '0) pulse_d = 1'b0;
      else              wcnt_d  = wcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q   <= '0;
      rem_q   <= '0;
      pulse_q <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      ivl_q   <= ivl_d;
      rem_q   <= rem_d;
      pulse_q <= pulse_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign pulse = pulse_q;

  // R9
  pulse_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> ($past(tick) && ($past(ivl_q) != '0) && ($past(prsc) != '0)));
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_we |=> (rem_q == $past(ivl_wdata)));
  // R8
  width_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_q) |-> $past(tick));
endmodule

// File: rtl/ptp_fiper_timer.sv
module ptp_fiper_timer
  import ptp_tmr_pkg::*;
#(
  parameter int PER_W  = 8,
  parameter int PRSC_W = 16,
  parameter int IVL_W  = 32,
  parameter int N_IVL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addend_we,
  input  logic [31:0]       addend_wdata,
  input  logic              period_we,
  input  logic [PER_W-1:0]  period_wdata,
  input  logic              prsc_we,
  input  logic [PRSC_W-1:0] prsc_wdata,
  input  logic [N_IVL-1:0]  ivl_we,
  input  logic [IVL_W-1:0]  ivl_wdata,
  input  logic              time_we,
  input  logic [63:0]       time_wdata,
  output logic              tick,
  output logic [63:0]       time_ns,
  output logic              oclk_stb,
  output logic [N_IVL-1:0]  pulse
);
  logic [PER_W-1:0]  period;
  logic [PRSC_W-1:0] prsc;

  ptp_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .addend_we(addend_we),
    .addend_wdata(addend_wdata), .tick(tick)
  );

  ptp_ns_counter #(.PER_W(PER_W)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .period_we(period_we), .period_wdata(period_wdata),
    .time_we(time_we), .time_wdata(time_wdata),
    .time_ns(time_ns), .period(period)
  );

  ptp_prescaler #(.PRSC_W(PRSC_W)) u_prsc (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .prsc_we(prsc_we), .prsc_wdata(prsc_wdata),
    .oclk_stb(oclk_stb), .prsc(prsc)
  );

  for (genvar g = 0; g < N_IVL; g++) begin : g_ivl
    ptp_ivl_gen #(.PER_W(PER_W), .PRSC_W(PRSC_W), .IVL_W(IVL_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .tick(tick), .period(period), .prsc(prsc),
      .ivl_we(ivl_we[g]), .ivl_wdata(ivl_wdata), .pulse(pulse[g])
    );
  end

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tick && !oclk_stb && pulse == '0));
endmodule

// File: tb/test_ptp_fiper_timer.sv
module test_ptp_fiper_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addend_we;
  logic [31:0] addend_wdata;
  logic        period_we;
  logic [7:0]  period_wdata;
  logic        prsc_we;
  logic [15:0] prsc_wdata;
  logic [1:0]  ivl_we;
  logic [31:0] ivl_wdata;
  logic        time_we;
  logic [63:0] time_wdata;
  logic        tick;
  logic [63:0] time_ns;
  logic        oclk_stb;
  logic [1:0]  pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ptp_fiper_timer i_ptp_fiper_timer (
    .clk(clk), .rst_n(rst_n), .addend_we(addend_we), .addend_wdata(addend_wdata),
    .period_we(period_we), .period_wdata(period_wdata), .prsc_we(prsc_we),
    .prsc_wdata(prsc_wdata), .ivl_we(ivl_we), .ivl_wdata(ivl_wdata),
    .time_we(time_we), .time_wdata(time_wdata), .tick(tick), .time_ns(time_ns),
    .oclk_stb(oclk_stb), .pulse(pulse)
  );

  // scoreboard: expected items queued by the driver, popped by the monitor
  typedef struct { string req; longint unsigned val; } exp_t;
  exp_t exp_q[$];

  task automatic expect_val(input string req, input longint unsigned v);
    exp_t e;
    e.req = req; e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic observe(input longint unsigned act);
    exp_t e;
    e = exp_q.pop_front();
    checks++;
    if (act !== e.val) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", e.req, act, e.val);
    end
  endtask

  // port monitor
  longint unsigned tick_cnt = 0;
  int stb_cnt = 0;
  int rise_cnt [2];
  int since [2];
  int hw [2];
  int last_per [2];
  int last_w [2];
  logic [1:0] prev_p = 2'b00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tick) tick_cnt++;
      if (oclk_stb) stb_cnt++;
      for (int g = 0; g < 2; g++) begin
        if (pulse[g] && !prev_p[g]) begin
          rise_cnt[g]++;
          last_per[g] = since[g];
          since[g] = 0;
          hw[g] = 0;
        end
        if (!pulse[g] && prev_p[g]) last_w[g] = hw[g];
        if (tick) begin
          since[g]++;
          if (pulse[g]) hw[g]++;
        end
      end
      prev_p = pulse;
    end
  end

  task automatic clear_mon();
    tick_cnt = 0; stb_cnt = 0;
    for (int g = 0; g < 2; g++) begin
      rise_cnt[g] = 0; since[g] = 0; hw[g] = 0; last_per[g] = -1; last_w[g] = -1;
    end
  endtask

  task automatic wr_addend(input logic [31:0] v);
    @(negedge clk); addend_we = 1'b1; addend_wdata = v;
    @(negedge clk); addend_we = 1'b0;
  endtask

  task automatic wr_ivl(input int g, input logic [31:0] v);
    @(negedge clk); ivl_we = 2'b00; ivl_we[g] = 1'b1; ivl_wdata = v;
    @(negedge clk); ivl_we = 2'b00;
  endtask

  task automatic wr_prsc(input logic [15:0] v);
    @(negedge clk); prsc_we = 1'b1; prsc_wdata = v;
    @(negedge clk); prsc_we = 1'b0;
  endtask

  task automatic stop_ticks();
    wr_addend(32'h0);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_pulses(input int cycles);
    clear_mon();
    wr_addend(32'h8000_0000);
    repeat (cycles) @(negedge clk);
    stop_ticks();
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint unsigned win, x2;
    rst_n = 1'b0; addend_we = 0; addend_wdata = 0; period_we = 0; period_wdata = 0;
    prsc_we = 0; prsc_wdata = 0; ivl_we = 0; ivl_wdata = 0; time_we = 0; time_wdata = 0;
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_val("R1 time", 0);      observe(time_ns);
    expect_val("R1 outputs", 0);   observe({tick, oclk_stb, pulse});
    repeat (20) @(negedge clk);
    // R2 zero addend, no ticks
    expect_val("R2 zero addend", 0); observe(tick_cnt);

    @(negedge clk); period_we = 1'b1; period_wdata = 8'd10;
    @(negedge clk); period_we = 1'b0;

    // R2 exact tick count from phase zero
    @(negedge clk); addend_we = 1'b1; addend_wdata = 32'h9999_99A4;
    @(negedge clk); addend_we = 1'b0;
    win = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (tick) win++;
    end
    expect_val("R2 tick count", (64'd3000 * 64'h9999_99A4) >> 32); observe(win);

    // R5 addend change mid-run, then stop
    wr_addend(32'h4000_0000);
    repeat (500) @(negedge clk);
    stop_ticks();
    // R3 R5 time equals period times ticks
    expect_val("R3/R5 time", 64'd10 * tick_cnt); observe(time_ns);

    // R4 load while idle
    @(negedge clk); time_we = 1'b1; time_wdata = 64'h0123_4567_89AB_CDE0;
    @(negedge clk); time_we = 1'b0;
    expect_val("R4 idle load", 64'h0123_4567_89AB_CDE0); observe(time_ns);

    // R4 load while ticking every other cycle, overriding any tick
    wr_addend(32'h8000_0000);
    repeat (7) @(negedge clk);
    x2 = 64'hFFFF_FFFF_FFFF_FF00;
    for (int k = 0; k < 2; k++) begin
      time_we = 1'b1; time_wdata = x2 + 64'(k);
      @(posedge clk); #1 time_we = 1'b0; tick_cnt = 0;
      @(negedge clk);
      expect_val("R4 busy load", x2 + 64'(k)); observe(time_ns);
    end
    x2 = x2 + 64'd1;
    repeat (100) @(negedge clk);
    stop_ticks();
    expect_val("R3/R4 after load", x2 + 64'd10 * tick_cnt); observe(time_ns);

    // R6 R7 R8 R10: prescale 4, gen0 K=12, gen1 K=floor(45/10)+1=5
    wr_prsc(16'd4);
    wr_ivl(0, 32'd110);
    wr_ivl(1, 32'd45);
    run_pulses(600);
    expect_val("R6 strobes", tick_cnt / 4);       observe(stb_cnt);
    expect_val("R7 gen0 rises", tick_cnt / 12);   observe(rise_cnt[0]);
    expect_val("R7 gen1 rises", tick_cnt / 5);    observe(rise_cnt[1]);
    expect_val("R7 gen0 period", 12);             observe(last_per[0]);
    expect_val("R10 gen1 period", 5);             observe(last_per[1]);
    expect_val("R8 gen0 width", 4);               observe(last_w[0]);
    expect_val("R8 gen1 width", 4);               observe(last_w[1]);

    // R8 width follows prescale 2; R10 rewriting gen1 leaves gen0 period
    wr_prsc(16'd2);
    wr_ivl(0, 32'd110);
    wr_ivl(1, 32'd70);
    run_pulses(400);
    expect_val("R8 width p2", 2);                 observe(last_w[0]);
    expect_val("R10 gen0 period", 12);            observe(last_per[0]);
    expect_val("R7 gen1 period 8", 8);            observe(last_per[1]);

    // R9 zero interval on gen0, gen1 keeps running
    wr_ivl(0, 32'd0);
    wr_ivl(1, 32'd45);
    run_pulses(300);
    expect_val("R9 gen0 off", 0);                 observe(rise_cnt[0]);
    expect_val("R10 gen1 alone", tick_cnt / 5);   observe(rise_cnt[1]);

    // R9 R6 zero prescale
    wr_prsc(16'd0);
    wr_ivl(1, 32'd45);
    run_pulses(300);
    expect_val("R9 prsc0 pulses", 0);             observe(rise_cnt[1]);
    expect_val("R6 prsc0 strobes", 0);            observe(stb_cnt);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule